// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor port that issues single-byte loads and stores and a slower memory port that moves whole 8-byte lines. It holds 32 lines of 8 bytes (256 bytes in all) for a 16-bit byte address space. Every block of memory maps to exactly one line, chosen by the middle address bits. The top address bits are kept as a tag beside the line, together with a valid bit and a modified bit.

The processor starts an access by raising `cpu_req` for a clock edge on which the block is idle. The block captures the address, the write enable and the write byte, and looks up the line on the next cycle. On a hit, `cpu_ready` pulses high in that cycle with the load byte on `cpu_rdata`. A store hit changes only the cached byte and marks the line modified. On a miss the block first writes the old line back to memory, but only if it is valid and modified. It then reads the whole new line and repeats the lookup, which now hits. A store miss allocates the line in the same way and merges its byte after the fill. Requests raised while the block is busy are ignored.

Top module: `wb_dm_cache`

## Requirements
- R1: Reset (synchronous, active high) clears every valid and modified bit. After reset `cpu_ready` and `mem_req` are low, and the first access to any line misses and issues no line write.
- R2: The address splits into tag = addr[15:8], line index = addr[7:3] and byte offset = addr[2:0]. `mem_addr` always carries a line base, with bits [2:0] equal to 000.
- R3: A hit raises `cpu_ready` in the cycle after the accepting edge. On a load, `cpu_rdata` then holds the byte at the offset. A hit makes no memory transfer.
- R4: A miss on a clean or invalid line makes exactly one line read at {addr[15:3],000} and installs all 8 bytes. The lookup that follows hits in the cycle after `mem_ack`, and the other bytes of that block then hit.
- R5: A store hit updates only the addressed cached byte, sets the line's modified bit and makes no memory write.
- R6: A miss on a valid modified line first writes the line to {stored tag, index, 000} with its current contents (`mem_we` = 1). It then reads the new line.
- R7: A miss on a valid clean line overwrites it with no line write.
- R8: A store miss allocates the line: victim write-back if modified, then line fill, then byte merge. The line is left modified, so its later eviction writes the stored byte back.
- R9: `cpu_ready` stays low from a miss until the retried lookup hits. It is never high while `mem_req` is high.
- R10: `mem_req`, `mem_we` and `mem_addr` hold steady until the cycle in which `mem_ack` is high. One acknowledge ends one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | 16 | Line base address |
| mem_wdata | output | 64 | Line written back, byte 0 in bits [7:0] |
| mem_rdata | input | 64 | Fill line, byte 0 in bits [7:0], valid with mem_ack |
| mem_ack | input | 1 | Transfer completes in this cycle |

## Verification
The bench aims at tag conflicts on the same index. Two blocks that share line 3, and two that share line 21, are alternated so that modified and clean victims both occur. A design that skipped the write-back, or wrote to the new tag's address, would return stale data when the first block is read again. A store to an empty line checks allocation order: a design that merged the byte before the fill would lose the byte. A design that never set the modified bit would drop it at eviction. A reset while a line is modified must leave that line invalid, with no write-back on the next access. The same applies to the first use of never-filled lines. A design that kept the valid bits across reset would hit with stale data or write back garbage.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int ADDR_W     = 16;
    localparam int TAG_W      = 8;
    localparam int IDX_W      = 5;
    localparam int OFF_W      = 3;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int LINE_W     = 8 * LINE_BYTES;
    localparam int NUM_LINES  = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [7:0]        byte_t;
    typedef logic [LINE_W-1:0] line_t;

    // Field order matters: tag high, index middle, offset low.
    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } addr_split_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_EVICT  = 2'd2,
        ST_REFILL = 2'd3
    } cstate_e;

    function automatic addr_t line_base(tag_t t, idx_t i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction

    function automatic byte_t pick_byte(line_t l, off_t o);
        return l[{o, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic clk,
    input  logic rst,
    input  idx_t idx,
    output tag_t rd_tag,
    output logic rd_valid,
    output logic rd_dirty,
    input  logic fill_en,
    input  tag_t fill_tag,
    input  logic mark_dirty
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    tag_t             tags_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tags_q[idx] <= fill_tag;
    end

    assign rd_tag   = tags_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        mark_dirty |-> valid_q[idx]); // R5

    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (rd_valid && !rd_dirty)); // R7

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
    import cache_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic  clk,
    input  idx_t  idx,
    output line_t rd_line,
    input  logic  line_we,
    input  line_t line_data,
    input  logic  byte_we,
    input  off_t  byte_off,
    input  byte_t byte_data
);

    line_t lines_q [LINES];

    always_ff @(posedge clk) begin
        if (line_we)
            lines_q[idx] <= line_data;
        else if (byte_we)
            lines_q[idx][{byte_off, 3'b000} +: 8] <= byte_data;
    end

    assign rd_line = lines_q[idx];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  byte_t cpu_wdata,
    output logic  cpu_ready,
    input  tag_t  rd_tag,
    input  logic  rd_valid,
    input  logic  rd_dirty,
    output idx_t  req_idx,
    output off_t  req_off,
    output tag_t  req_tag,
    output byte_t req_wdata,
    output logic  fill_en,
    output logic  mark_dirty,
    output logic  byte_we,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    input  logic  mem_ack
);

    cstate_e     state_q, state_d;
    addr_split_t req_q;
    logic        we_q;
    byte_t       wd_q;
    logic        hit;

    assign hit       = rd_valid && (rd_tag == req_q.tag);
    assign req_idx   = req_q.idx;
    assign req_off   = req_q.off;
    assign req_tag   = req_q.tag;
    assign req_wdata = wd_q;

    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        byte_we    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    cpu_ready  = 1'b1;
                    byte_we    = we_q;
                    mark_dirty = we_q;
                    state_d    = ST_IDLE;
                end else if (rd_valid && rd_dirty) begin
                    state_d = ST_EVICT;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = line_base(rd_tag, req_q.idx);
                if (mem_ack) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = line_base(req_q.tag, req_q.idx);
                if (mem_ack) begin
                    fill_en = 1'b1;
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                req_q <= addr_split_t'(cpu_addr);
                we_q  <= cpu_we;
                wd_q  <= cpu_wdata;
            end
        end
    end

    AST_ACCEPT_TO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req) |=> (state_q == ST_LOOKUP)); // R3

    AST_READY_NOT_DURING_MEM: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R6

    AST_RETRY_HITS: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> cpu_ready); // R4

endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    tag_t  rd_tag, req_tag;
    logic  rd_valid, rd_dirty;
    idx_t  req_idx;
    off_t  req_off;
    byte_t req_wdata;
    logic  fill_en, mark_dirty, byte_we;
    line_t rd_line;

    cache_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .rd_tag     (rd_tag),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .req_idx    (req_idx),
        .req_off    (req_off),
        .req_tag    (req_tag),
        .req_wdata  (req_wdata),
        .fill_en    (fill_en),
        .mark_dirty (mark_dirty),
        .byte_we    (byte_we),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack)
    );

    cache_tag_store #(.LINES(NUM_LINES)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_idx),
        .rd_tag     (rd_tag),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .fill_en    (fill_en),
        .fill_tag   (req_tag),
        .mark_dirty (mark_dirty)
    );

    cache_data_store #(.LINES(NUM_LINES)) u_data (
        .clk        (clk),
        .idx        (req_idx),
        .rd_line    (rd_line),
        .line_we    (fill_en),
        .line_data  (mem_rdata),
        .byte_we    (byte_we),
        .byte_off   (req_off),
        .byte_data  (req_wdata)
    );

    assign mem_wdata = rd_line;
    assign cpu_rdata = pick_byte(rd_line, req_off);

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R2

endmodule

// File: tb/tb_wb_dm_cache.sv
module tb_wb_dm_cache;

    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;

    wb_dm_cache dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: sparse byte store over a computed background pattern.
    logic [7:0] mem_b [int];

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (mem_b.exists(int'(a))) return mem_b[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    int          rd_cnt = 0, wr_cnt = 0;
    logic        wb_before_fill = 1'b0;
    logic [15:0] last_fill_addr = '0, last_wb_addr = '0;
    int          lat_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT - 1) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        mem_b[int'(mem_addr) + b] = mem_wdata[b*8 +: 8];
                    wr_cnt++;
                    last_wb_addr = mem_addr;
                end else begin
                    logic [63:0] l;
                    for (int b = 0; b < 8; b++)
                        l[b*8 +: 8] = mem_byte(mem_addr + 16'(b));
                    mem_rdata <= l;
                    rd_cnt++;
                    last_fill_addr = mem_addr;
                    wb_before_fill = (wr_cnt > 0);
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Port monitors, sampled at the falling edge.
    int          ready_mem_viol = 0, hold_viol = 0;
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [15:0] p_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_ready && mem_req) ready_mem_viol++;
            if (p_req && !p_ack && !(mem_req && mem_addr == p_addr && mem_we == p_we))
                hold_viol++;
        end
        p_req = mem_req && !rst; p_ack = mem_ack; p_addr = mem_addr; p_we = mem_we;
    end

    int          acc_lat;
    logic [7:0]  acc_data;

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; wb_before_fill = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        acc_lat = 1;
        while (!cpu_ready && acc_lat < 200) begin
            @(negedge clk);
            acc_lat++;
        end
        acc_data = cpu_rdata;
        check(cpu_ready, "R9 access completes", acc_lat, 0);
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [1:0]  kind;   // 0 hit, 1 miss without write-back, 2 miss with write-back
        logic [15:0] wb_addr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1118, 8'h00, 2'd1, 16'h0000},
        '{1'b0, 16'h111B, 8'h00, 2'd0, 16'h0000},
        '{1'b1, 16'h111C, 8'hA5, 2'd0, 16'h0000},
        '{1'b0, 16'h111C, 8'h00, 2'd0, 16'h0000},
        '{1'b0, 16'hD01D, 8'h00, 2'd2, 16'h1118},
        '{1'b0, 16'h1118, 8'h00, 2'd1, 16'h0000},
        '{1'b0, 16'h111C, 8'h00, 2'd0, 16'h0000},
        '{1'b1, 16'hAAAA, 8'h3C, 2'd1, 16'h0000},
        '{1'b0, 16'hAAAA, 8'h00, 2'd0, 16'h0000},
        '{1'b0, 16'hAAAB, 8'h00, 2'd0, 16'h0000},
        '{1'b0, 16'h00AA, 8'h00, 2'd2, 16'hAAA8},
        '{1'b0, 16'hAAAA, 8'h00, 2'd1, 16'h0000},
        '{1'b0, 16'h0000, 8'h00, 2'd1, 16'h0000},
        '{1'b1, 16'h0007, 8'hFF, 2'd0, 16'h0000},
        '{1'b0, 16'h0000, 8'h00, 2'd0, 16'h0000}
    };

    logic [7:0] shadow [int];

    function automatic logic [7:0] truth(input logic [15:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0, "R1 ready low after reset", cpu_ready, 0);
        check(mem_req == 1'b0, "R1 mem_req low after reset", mem_req, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            access(v.we, v.addr, v.wd);
            if (v.kind == 2'd0) begin
                check(acc_lat == 1, "R3 hit latency", acc_lat, 1);
                check(rd_cnt == 0 && wr_cnt == 0, v.we ? "R5 store hit no memory" : "R3 hit no memory",
                      rd_cnt + wr_cnt, 0);
            end else begin
                check(rd_cnt == 1, "R4 one line fill", rd_cnt, 1);
                check(last_fill_addr == {v.addr[15:3], 3'b000}, "R2 fill at line base",
                      last_fill_addr, {v.addr[15:3], 3'b000});
                check(acc_lat > 1, "R9 miss stalls", acc_lat, 2);
                if (v.kind == 2'd1) begin
                    check(wr_cnt == 0, i == 0 || i == 12 ? "R1 empty line no write-back" : "R7 clean victim", wr_cnt, 0);
                end else begin
                    check(wr_cnt == 1, "R6 modified victim written", wr_cnt, 1);
                    check(last_wb_addr == v.wb_addr, "R6 write-back address", last_wb_addr, v.wb_addr);
                    check(wb_before_fill, "R6 write-back before fill", wb_before_fill, 1);
                end
            end
            if (v.we) begin
                shadow[int'(v.addr)] = v.wd;
            end else begin
                check(acc_data == truth(v.addr), i == 6 || i == 11 ? "R8 stored byte survives eviction" : "R4 load data",
                      acc_data, truth(v.addr));
            end
        end

        // Reset while line 0 holds a modified byte: it must be dropped, not written back.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 idle after mid-run reset", cpu_ready, 0);
        rst = 1'b0;
        access(1'b0, 16'h0007, 8'h00);
        check(wr_cnt == 0, "R1 valid cleared, no write-back", wr_cnt, 0);
        check(rd_cnt == 1, "R1 miss after reset", rd_cnt, 1);
        check(acc_data == mem_byte(16'h0007), "R1 data from memory", acc_data, mem_byte(16'h0007));

        // Store miss into a modified line: write-back, fill, then merge.
        access(1'b1, 16'h0005, 8'h77);
        check(acc_lat == 1, "R5 store hit on refilled line", acc_lat, 1);
        access(1'b1, 16'h4402, 8'h99);
        check(wr_cnt == 1 && last_wb_addr == 16'h0000, "R8 store miss evicts modified line", last_wb_addr, 0);
        check(rd_cnt == 1 && last_fill_addr == 16'h4400, "R8 store miss fills", last_fill_addr, 16'h4400);
        check(mem_byte(16'h0005) == 8'h77, "R6 evicted byte in memory", mem_byte(16'h0005), 8'h77);
        access(1'b0, 16'h4402, 8'h00);
        check(acc_lat == 1 && acc_data == 8'h99, "R8 merged byte", acc_data, 8'h99);
        access(1'b0, 16'h4403, 8'h00);
        check(acc_data == mem_byte(16'h4403), "R8 rest of line from fill", acc_data, mem_byte(16'h4403));

        check(ready_mem_viol == 0, "R9 ready never with mem_req", ready_mem_viol, 0);
        check(hold_viol == 0, "R10 request held until ack", hold_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule